// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the reservation state that backs load-reserve and store-conditional atomics for a few hardware threads that share one memory. Every thread owns one slot. A slot holds a valid flag and the address of one 128-byte line. Each slot is a two-state machine with the states RSV_NONE and RSV_HELD. The transitions are ACQUIRE (RSV_NONE to RSV_HELD), REPLACE (RSV_HELD to RSV_HELD with a new line) and DROP (RSV_HELD to RSV_NONE).

A request is a one-cycle pulse. It carries a thread ID, an operation, a base-register selector, the base and index operand values, and the memory word read for a load. The block forms the effective address and checks its alignment. It then updates the slots. One cycle later it reports the store-conditional outcome, any alignment fault, and the zero-extended word returned by a reserving load. Stores from agents outside the thread set arrive on a separate port and invalidate any reservation on the line they touch. A per-thread flush input stands for an exception or a context switch.

Top module: `lrsc_monitor`

## Requirements
- R1: The effective address is (base + index) truncated to 32 bits. When the base selector field is 0, the base is the constant zero and the base operand is ignored.
- R2: One cycle after an aligned reserving load, ld_valid_o is 1 and ld_data_o holds the memory word in bits 31:0 with zeros in bits 63:32.
- R3: A thread holds at most one reservation. A new reserving load replaces its earlier line, so a later store-conditional to the old line fails.
- R4: The reservation granule is a naturally aligned 128-byte line: address bits 31:7. A store-conditional to any aligned word of the reserved line succeeds.
- R5: A plain store (op 2) from another thread, or an external store, to any byte of a reserved line drops that reservation. A store to a different line leaves it intact.
- R6: A flush on a thread (exception or context switch) drops that thread's reservation.
- R7: A reserving load (op 0) or store-conditional (op 1) whose address has bits 1:0 not zero pulses align_fault_o one cycle later. It sets no reservation, and a store-conditional so faulted fails. Plain stores never fault.
- R8: One cycle after a store-conditional request, sc_valid_o is 1. sc_pass_o (the equal bit) is 1 only if the thread held a reservation on the addressed line.
- R9: A store-conditional clears the issuing thread's reservation whether it passes or fails. A passing one also drops other threads' reservations on that line.
- R10: If a reserving load and an external store to the same line occur in one cycle, the reservation ends up cleared.
- R11: Reset clears every reservation and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle request pulse |
| req_tid_i | input | 2 | Issuing thread |
| req_op_i | input | 2 | 0 reserving load, 1 store-conditional, 2 plain store, 3 none |
| req_base_sel_i | input | 5 | Base register field; 0 selects constant zero |
| req_base_i | input | 64 | Base operand value |
| req_index_i | input | 64 | Index operand value |
| mem_word_i | input | 32 | Word read from memory for a reserving load |
| ext_store_valid_i | input | 1 | Store by an outside agent |
| ext_store_addr_i | input | 32 | Address of the outside store |
| flush_i | input | 4 | Per-thread exception or context switch |
| sc_valid_o | output | 1 | Store-conditional result valid |
| sc_pass_o | output | 1 | Store-conditional succeeded (equal bit) |
| align_fault_o | output | 1 | Alignment fault pulse |
| ld_valid_o | output | 1 | Reserving-load data valid |
| ld_data_o | output | 64 | Zero-extended loaded word |

## Verification
Store-conditionals are driven after a fresh reservation, after a reservation replaced by a second load, after peer and external stores to the same line and to a neighbouring line, after a flush, and after a peer's passing store-conditional. This separates line-granular matching from word matching and separates each drop cause from the others. Address patterns with a zero base selector over a junk base, and a base plus index that carries past bit 63, show whether the address is formed correctly. A reserving load paired with a same-cycle external store to its line, and a reset in the middle of a run, cover the ordering corner cases.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_RSV   = 2'd0,
        OP_STORE_COND = 2'd1,
        OP_STORE      = 2'd2,
        OP_NONE       = 2'd3
    } lrsc_op_t;

    typedef enum logic {
        RSV_NONE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_t;
endpackage

// File: rtl/lrsc_addr_gen.sv
module lrsc_addr_gen #(
    parameter int XLEN      = 64,
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 5,
    parameter int LINE_BITS = 7,
    parameter int ALIGN_BITS = 2,
    localparam int LINE_W   = ADDR_W - LINE_BITS
) (
    input  logic [SEL_W-1:0]  base_sel_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   index_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [LINE_W-1:0] line_o,
    output logic              aligned_o
);
    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] sum;

    always_comb begin
        base_eff  = (base_sel_i == '0) ? '0 : base_i;
        sum       = base_eff + index_i;
        ea_o      = sum[ADDR_W-1:0];
        line_o    = ea_o[ADDR_W-1:LINE_BITS];
        aligned_o = (ea_o[ALIGN_BITS-1:0] == '0);
    end
endmodule

// File: rtl/lrsc_slot.sv
module lrsc_slot
    import lrsc_pkg::*;
#(
    parameter int LINE_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [LINE_W-1:0] set_line_i,
    input  logic              clr_i,
    input  logic              peer_kill_i,
    input  logic [LINE_W-1:0] peer_line_i,
    input  logic              ext_v_i,
    input  logic [LINE_W-1:0] ext_line_i,
    output logic              held_o,
    output logic [LINE_W-1:0] line_o
);
    rsv_state_t        state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              kill_cur;
    logic              kill_new;

    assign kill_cur = (peer_kill_i && peer_line_i == line_q) ||
                      (ext_v_i && ext_line_i == line_q);
    assign kill_new = ext_v_i && ext_line_i == set_line_i;

    // next-state: ACQUIRE, REPLACE, DROP
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        unique case (state_q)
            RSV_NONE: begin
                if (set_i && !clr_i && !kill_new) begin
                    state_d = RSV_HELD;
                    line_d  = set_line_i;
                end
            end
            RSV_HELD: begin
                if (clr_i) begin
                    state_d = RSV_NONE;
                end else if (set_i) begin
                    if (kill_new) begin
                        state_d = RSV_NONE;
                    end else begin
                        line_d = set_line_i;
                    end
                end else if (kill_cur) begin
                    state_d = RSV_NONE;
                end
            end
            default: state_d = RSV_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_NONE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        held_o = (state_q == RSV_HELD);
        line_o = line_q;
    end

    // R6
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !held_o);

    // R10
    ext_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && ext_v_i && ext_line_i == set_line_i) |=> !held_o);

    // R3
    acquire_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !(ext_v_i && ext_line_i == set_line_i))
        |=> (held_o && line_o == $past(set_line_i)));

    // R5
    ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !set_i && ext_v_i && ext_line_i == line_o) |=> !held_o);
endmodule

// File: rtl/lrsc_result_reg.sv
module lrsc_result_reg #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_v_i,
    input  logic              sc_pass_i,
    input  logic              fault_i,
    input  logic              ld_v_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sc_valid_o,
    output logic              sc_pass_o,
    output logic              align_fault_o,
    output logic              ld_valid_o,
    output logic [XLEN-1:0]   ld_data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_valid_o    <= 1'b0;
            sc_pass_o     <= 1'b0;
            align_fault_o <= 1'b0;
            ld_valid_o    <= 1'b0;
            ld_data_o     <= '0;
        end else begin
            sc_valid_o    <= sc_v_i;
            sc_pass_o     <= sc_pass_i;
            align_fault_o <= fault_i;
            ld_valid_o    <= ld_v_i;
            ld_data_o     <= ld_v_i ? {{(XLEN-WORD_W){1'b0}}, word_i} : '0;
        end
    end

    // R8
    pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass_o |-> sc_valid_o);

    // R7
    fault_never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> !sc_pass_o && !ld_valid_o);

    // R2
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> ld_data_o[XLEN-1:WORD_W] == '0);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int XLEN      = 64,
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 5,
    parameter int LINE_BITS = 7,
    localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int LINE_W   = ADDR_W - LINE_BITS,
    localparam int WORD_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic [TID_W-1:0]     req_tid_i,
    input  logic [1:0]           req_op_i,
    input  logic [SEL_W-1:0]     req_base_sel_i,
    input  logic [XLEN-1:0]      req_base_i,
    input  logic [XLEN-1:0]      req_index_i,
    input  logic [WORD_W-1:0]    mem_word_i,
    input  logic                 ext_store_valid_i,
    input  logic [ADDR_W-1:0]    ext_store_addr_i,
    input  logic [N_THREADS-1:0] flush_i,
    output logic                 sc_valid_o,
    output logic                 sc_pass_o,
    output logic                 align_fault_o,
    output logic                 ld_valid_o,
    output logic [XLEN-1:0]      ld_data_o
);
    lrsc_op_t          op;
    logic [ADDR_W-1:0] ea;
    logic [LINE_W-1:0] req_line;
    logic [LINE_W-1:0] ext_line;
    logic              aligned;
    logic              is_lr, is_sc, is_st;
    logic              sc_pass_now;
    logic              fault_now;

    logic [N_THREADS-1:0] held;
    logic [LINE_W-1:0]    slot_line [N_THREADS];

    lrsc_addr_gen #(
        .XLEN(XLEN), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
        .LINE_BITS(LINE_BITS), .ALIGN_BITS(2)
    ) u_addr (
        .base_sel_i(req_base_sel_i),
        .base_i    (req_base_i),
        .index_i   (req_index_i),
        .ea_o      (ea),
        .line_o    (req_line),
        .aligned_o (aligned)
    );

    always_comb begin
        op       = lrsc_op_t'(req_op_i);
        ext_line = ext_store_addr_i[ADDR_W-1:LINE_BITS];
        is_lr    = req_valid_i && op == OP_LOAD_RSV;
        is_sc    = req_valid_i && op == OP_STORE_COND;
        is_st    = req_valid_i && op == OP_STORE;
        fault_now = (is_lr || is_sc) && !aligned;
        sc_pass_now = is_sc && aligned
                   && held[req_tid_i]
                   && slot_line[req_tid_i] == req_line
                   && !flush_i[req_tid_i]
                   && !(ext_store_valid_i && ext_line == req_line);
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_slot
        logic mine;
        logic set_t, clr_t, peer_kill_t;

        always_comb begin
            mine        = (req_tid_i == TID_W'(t));
            set_t       = is_lr && mine && aligned;
            clr_t       = flush_i[t] || (is_sc && mine);
            peer_kill_t = !mine && (is_st || sc_pass_now);
        end

        lrsc_slot #(.LINE_W(LINE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_t),
            .set_line_i (req_line),
            .clr_i      (clr_t),
            .peer_kill_i(peer_kill_t),
            .peer_line_i(req_line),
            .ext_v_i    (ext_store_valid_i),
            .ext_line_i (ext_line),
            .held_o     (held[t]),
            .line_o     (slot_line[t])
        );

        // R9
        sc_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sc && mine) |=> !held[t]);
    end

    lrsc_result_reg #(.XLEN(XLEN), .WORD_W(WORD_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .sc_v_i       (is_sc),
        .sc_pass_i    (sc_pass_now),
        .fault_i      (fault_now),
        .ld_v_i       (is_lr && aligned),
        .word_i       (mem_word_i),
        .sc_valid_o   (sc_valid_o),
        .sc_pass_o    (sc_pass_o),
        .align_fault_o(align_fault_o),
        .ld_valid_o   (ld_valid_o),
        .ld_data_o    (ld_data_o)
    );

    // R7
    no_rsv_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lr && !aligned && !held[req_tid_i]) |=> !held[$past(req_tid_i)]);
endmodule

// File: tb/lrsc_monitor_test.sv
module lrsc_monitor_test;
    localparam int N_VEC = 28;

    typedef struct packed {
        logic        v;
        logic [1:0]  op;
        logic [1:0]  tid;
        logic [4:0]  sel;
        logic [63:0] base;
        logic [31:0] idx;
        logic        ext_v;
        logic [31:0] ext_a;
        logic [3:0]  flush;
        logic        exp_sc;
        logic        exp_pass;
        logic        exp_flt;
    } vec_t;

    // op: 0 reserving load, 1 store-conditional, 2 plain store
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 2'd0, 2'd0, 5'd1, 64'h1000, 32'h4, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 0  R1 R2
        '{1'b1, 2'd1, 2'd0, 5'd1, 64'h1000, 32'h7C, 1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0},      // 1  R4 R8
        '{1'b1, 2'd1, 2'd0, 5'd1, 64'h1000, 32'h7C, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},      // 2  R9
        '{1'b1, 2'd0, 2'd1, 5'd0, 64'hDEAD0000, 32'h2000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},// 3  R1
        '{1'b1, 2'd2, 2'd2, 5'd0, 64'h0, 32'h207F, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 4  R7 plain store
        '{1'b1, 2'd1, 2'd1, 5'd0, 64'h0, 32'h2000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 5  R5
        '{1'b1, 2'd0, 2'd1, 5'd0, 64'h0, 32'h2000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 6
        '{1'b1, 2'd0, 2'd1, 5'd0, 64'h0, 32'h3000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 7  R3
        '{1'b1, 2'd1, 2'd1, 5'd0, 64'h0, 32'h2000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 8  R3
        '{1'b1, 2'd0, 2'd1, 5'd0, 64'hDEAD0000, 32'h3000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},// 9  R1
        '{1'b1, 2'd1, 2'd1, 5'd0, 64'h0, 32'h3004, 1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0},       // 10 R1 R4
        '{1'b1, 2'd0, 2'd2, 5'd0, 64'h0, 32'h4002, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b1},       // 11 R7
        '{1'b1, 2'd1, 2'd2, 5'd0, 64'h0, 32'h4000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 12 R7
        '{1'b1, 2'd0, 2'd3, 5'd0, 64'h0, 32'h5000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 13
        '{1'b0, 2'd3, 2'd0, 5'd0, 64'h0, 32'h0, 1'b0, 32'h0, 4'h8, 1'b0, 1'b0, 1'b0},          // 14 R6
        '{1'b1, 2'd1, 2'd3, 5'd0, 64'h0, 32'h5000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 15 R6
        '{1'b1, 2'd0, 2'd0, 5'd0, 64'h0, 32'h6000, 1'b1, 32'h6040, 4'h0, 1'b0, 1'b0, 1'b0},    // 16 R10
        '{1'b1, 2'd1, 2'd0, 5'd0, 64'h0, 32'h6000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 17 R10
        '{1'b1, 2'd0, 2'd0, 5'd0, 64'h0, 32'h7000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 18
        '{1'b1, 2'd0, 2'd1, 5'd0, 64'h0, 32'h7010, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 19
        '{1'b1, 2'd1, 2'd0, 5'd0, 64'h0, 32'h7000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0},       // 20 R9
        '{1'b1, 2'd1, 2'd1, 5'd0, 64'h0, 32'h7010, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0},       // 21 R9
        '{1'b1, 2'd0, 2'd2, 5'd0, 64'h0, 32'h8000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0},       // 22
        '{1'b0, 2'd3, 2'd0, 5'd0, 64'h0, 32'h0, 1'b1, 32'h8080, 4'h0, 1'b0, 1'b0, 1'b0},       // 23 R5
        '{1'b1, 2'd1, 2'd2, 5'd0, 64'h0, 32'h8000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0},       // 24 R5
        '{1'b1, 2'd0, 2'd3, 5'd5, 64'hFFFF_FFFF_FFFF_F000, 32'h1000_2000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0}, // 25 R1
        '{1'b1, 2'd1, 2'd3, 5'd0, 64'h0, 32'h1000_1000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0},  // 26 R1
        '{1'b1, 2'd1, 2'd2, 5'd0, 64'h0, 32'h9001, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b1}        // 27 R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_tid = '0;
    logic [1:0]  req_op = 2'd3;
    logic [4:0]  req_sel = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_index = '0;
    logic [31:0] mem_word = '0;
    logic        ext_v = 1'b0;
    logic [31:0] ext_a = '0;
    logic [3:0]  flush = '0;
    logic        sc_valid, sc_pass, align_fault, ld_valid;
    logic [63:0] ld_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lrsc_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_tid_i(req_tid), .req_op_i(req_op),
        .req_base_sel_i(req_sel), .req_base_i(req_base), .req_index_i(req_index),
        .mem_word_i(mem_word), .ext_store_valid_i(ext_v), .ext_store_addr_i(ext_a),
        .flush_i(flush),
        .sc_valid_o(sc_valid), .sc_pass_o(sc_pass), .align_fault_o(align_fault),
        .ld_valid_o(ld_valid), .ld_data_o(ld_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_op = 2'd3; ext_v = 1'b0; flush = '0;
    endtask

    task automatic drive(input vec_t r, input logic [31:0] w);
        req_valid = r.v; req_op = r.op; req_tid = r.tid; req_sel = r.sel;
        req_base = r.base; req_index = {32'h0, r.idx};
        ext_v = r.ext_v; ext_a = r.ext_a; flush = r.flush; mem_word = w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 sc_valid at reset", {63'h0, sc_valid}, 64'h0);
        check("R11 ld_data at reset", ld_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            logic [31:0] w;
            logic exp_ld;
            w = 32'hA500_0000 + 32'(i);
            exp_ld = VECS[i].v && VECS[i].op == 2'd0 && !VECS[i].exp_flt;
            drive(VECS[i], w);
            @(negedge clk);
            idle();
            // R8 R4 R3 R5 R6 R9 R10 outcomes
            check($sformatf("R8 row %0d sc_valid/pass", i),
                  {62'h0, sc_valid, sc_pass}, {62'h0, VECS[i].exp_sc, VECS[i].exp_pass});
            check($sformatf("R7 row %0d align_fault", i),
                  {63'h0, align_fault}, {63'h0, VECS[i].exp_flt});
            check($sformatf("R2 row %0d ld", i),
                  {ld_valid, ld_data[62:0]}, exp_ld ? {1'b1, 31'h0, w} : 64'h0);
            if (exp_ld) check($sformatf("R2 row %0d upper", i), {32'h0, ld_data[63:32]}, 64'h0);
        end

        // R11 reset mid-run drops a held reservation
        drive('{1'b1, 2'd0, 2'd2, 5'd0, 64'h0, 32'hA000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0}, 32'h1);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 outputs cleared in reset", {61'h0, sc_valid, align_fault, ld_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive('{1'b1, 2'd1, 2'd2, 5'd0, 64'h0, 32'hA000, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0}, 32'h0);
        @(negedge clk);
        idle();
        check("R11 sc after reset fails", {62'h0, sc_valid, sc_pass}, 64'h2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule